// File: doc/BRIEF.md
# Burst-of-Four Separate-I/O Double-Data-Rate SRAM

This block is a cycle-accurate, synthesizable model of a static RAM with separate input and output data buses and a fixed burst of four words. Commands are sampled once per K cycle: an address plus two active-low strobes, one asking for a read and one for a write. Write data enters as four half-cycle beats starting one K cycle after the command. Read data leaves as four half-cycle beats starting three K cycles after the command. Outside the read beats, the output bus floats. Because the two data buses are independent, the bursts of a read and a write issued on neighbouring K edges run over each other in time without conflict.

Half-cycle timing uses a single beat clock running at twice the K rate. A phase register in the decoder marks which beat edges are K rising edges. It has two states, `PH_RISE` and `PH_FALL`, and toggles between them on every beat edge. Reset leaves it in `PH_RISE`, so the first beat edge after reset is a K edge. Each of the two burst sequencers (one for writes, one for reads) has a delay line that holds a command for its lag. Each also has a four-state machine: `SQ_IDLE` moves to `SQ_B1` when the delay line presents a command, emitting beat 0 on that edge. `SQ_B1` moves to `SQ_B2`, `SQ_B2` to `SQ_B3`, and `SQ_B3` back to `SQ_IDLE`. These emit beats 1, 2 and 3. The storage is a parameterised register array of 4 × 2^AW words.

Top module: `qdrb4_sram`

## Requirements
- R1: While reset is asserted and right after it, `q_oe` is 0, `q_out` floats and `cmd_err` is 0.
- R2: Strobes are sampled only on K edges (even beat edges, counting the first edge after reset as beat 0). On such an edge, `rd_n` low selects a read. Otherwise `wr_n` low selects a write, and both high is a deselect. If both are low, the read wins and the write is dropped without an error. Strobe levels at odd beat edges have no effect.
- R3: A write accepted at beat edge t captures `d_in` at beat edges t+2, t+3, t+4 and t+5 into word `addr*4+n` for beat n = 0..3.
- R4: A read accepted at beat edge t presents word `addr*4+n` on `q_out` from beat edge t+6+n for beat n = 0..3.
- R5: `q_oe` is 1 exactly in the beats that carry read data, and `q_out` is high-impedance whenever `q_oe` is 0.
- R6: A read may follow a write, or a write a read, on the next K edge. Both bursts complete with correct data on their own buses.
- R7: A command of the same type as one accepted on the previous K edge is ignored and sets the sticky flag `cmd_err`. It does not stop a command of the other type on that edge from being accepted.
- R8: Each read beat returns the array as it stands just before that beat edge. A write beat committed on the same edge is not visible, and one committed on an earlier edge is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_beat | input | 1 | Beat clock, twice the K rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe, sampled on K edges |
| wr_n | input | 1 | Active-low write strobe, sampled on K edges |
| addr | input | AW | Burst base address |
| d_in | input | DW | Write data beat |
| q_out | output | DW | Read data beat, high-impedance when idle |
| q_oe | output | 1 | High while `q_out` carries a read beat |
| cmd_err | output | 1 | Sticky flag for a too-early same-type command |

## Verification
The hardest situation to reach is a read whose beats land on the same words, in the same beat edges, as a write that is still committing. This exposes whether a read sees old or new data. The stimulus issues a read and then, two K cycles later, a write to the same address, so that every read beat coincides with the matching write beat and must return the old word. It then issues a read followed by a write one K cycle later, where every word is committed before it is read. Further stimulus drives strobes low on odd beat edges throughout, and combines a blocked read with a fresh write on a single edge. The scoreboard's own array and beat schedule predict each beat, including the dropped commands.

// File: rtl/qdrb4_pkg.sv
`timescale 1ns/1ps
package qdrb4_pkg;

    // Words moved per command and the width of the beat index.
    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = $clog2(BURST_LEN);

    // Position of a beat edge within the K cycle.
    typedef enum logic {
        PH_RISE,
        PH_FALL
    } kphase_e;

    // Burst sequencer: idle (beat 0 issued on launch) and beats 1..3.
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_B1,
        SQ_B2,
        SQ_B3
    } seq_state_e;

endpackage

// File: rtl/qdrb4_decode.sv
`timescale 1ns/1ps
module qdrb4_decode
    import qdrb4_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    output logic          k_rise,
    output logic          rd_go,
    output logic          wr_go,
    output logic [AW-1:0] go_addr,
    output logic          err
);

    kphase_e ph_q;
    logic    rd_last_q;
    logic    wr_last_q;
    logic    err_q;
    logic    rd_blocked;
    logic    wr_blocked;

    // Decode: read has priority; same-type repeats on the next K edge are dropped.
    always_comb begin
        k_rise     = (ph_q == PH_RISE);
        rd_go      = k_rise && !rd_n && !rd_last_q;
        rd_blocked = k_rise && !rd_n && rd_last_q;
        wr_go      = k_rise && !wr_n && !rd_go && !wr_last_q;
        wr_blocked = k_rise && !wr_n && !rd_go && wr_last_q;
        go_addr    = addr;
        err        = err_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q      <= PH_RISE;
            rd_last_q <= 1'b0;
            wr_last_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            unique case (ph_q)
                PH_RISE: ph_q <= PH_FALL;
                PH_FALL: ph_q <= PH_RISE;
                default: ph_q <= PH_RISE;
            endcase
            if (k_rise) begin
                rd_last_q <= rd_go;
                wr_last_q <= wr_go;
            end
            if (rd_blocked || wr_blocked) begin
                err_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/qdrb4_burst_seq.sv
`timescale 1ns/1ps
module qdrb4_burst_seq
    import qdrb4_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [AW-1:0]     beat_addr
);

    logic [DELAY-1:0]         pv_q;
    logic [DELAY-1:0][AW-1:0] pa_q;
    logic                     launch;
    seq_state_e               st_q;
    seq_state_e               st_d;
    logic [AW-1:0]            ba_q;

    // Delay line that holds each command until its first beat edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv_q <= '0;
        end else begin
            pv_q[0] <= start;
            for (int i = 1; i < DELAY; i++) begin
                pv_q[i] <= pv_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        pa_q[0] <= start_addr;
        for (int i = 1; i < DELAY; i++) begin
            pa_q[i] <= pa_q[i-1];
        end
    end

    assign launch = pv_q[DELAY-1];

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: if (launch) st_d = SQ_B1;
            SQ_B1:   st_d = SQ_B2;
            SQ_B2:   st_d = SQ_B3;
            SQ_B3:   st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    // State register and held burst base.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE;
            ba_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE && launch) begin
                ba_q <= pa_q[DELAY-1];
            end
        end
    end

    // Beat outputs.
    always_comb begin
        beat_valid = 1'b1;
        beat_idx   = '0;
        beat_addr  = ba_q;
        unique case (st_q)
            SQ_IDLE: begin
                beat_valid = launch;
                beat_addr  = pa_q[DELAY-1];
            end
            SQ_B1:   beat_idx = BEAT_W'(1);
            SQ_B2:   beat_idx = BEAT_W'(2);
            SQ_B3:   beat_idx = BEAT_W'(3);
            default: beat_valid = 1'b0;
        endcase
    end

    // Same-type spacing upstream guarantees a new burst only starts when idle.
    assert_launch_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (st_q == SQ_IDLE));

    // Beats of one burst advance by one index per beat edge.
    assert_beat_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_idx != BEAT_W'(3)) |=>
            (beat_valid && beat_idx == BEAT_W'($past(beat_idx) + BEAT_W'(1))));

endmodule

// File: rtl/qdrb4_store.sv
`timescale 1ns/1ps
module qdrb4_store
    import qdrb4_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW+BEAT_W-1:0] waddr,
    input  logic [DW-1:0]        wdata,
    input  logic [AW+BEAT_W-1:0] raddr,
    output logic [DW-1:0]        rdata
);

    localparam int WORDS = 1 << (AW + BEAT_W);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/qdrb4_sram.sv
`timescale 1ns/1ps
module qdrb4_sram
    import qdrb4_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int WR_LAG_K = 1,
    parameter int RD_LAT_K = 3
) (
    input  logic          clk_beat,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] q_out,
    output logic          q_oe,
    output logic          cmd_err
);

    localparam int WR_DLY = 2 * WR_LAG_K;
    localparam int RD_DLY = 2 * RD_LAT_K;

    logic              k_rise;
    logic              rd_go;
    logic              wr_go;
    logic [AW-1:0]     go_addr;
    logic              wr_bv;
    logic [BEAT_W-1:0] wr_idx;
    logic [AW-1:0]     wr_base;
    logic              rd_bv;
    logic [BEAT_W-1:0] rd_idx;
    logic [AW-1:0]     rd_base;
    logic [DW-1:0]     rd_word;
    logic [DW-1:0]     q_q;
    logic              oe_q;

    qdrb4_decode #(.AW(AW)) u_dec (
        .clk     (clk_beat),
        .rst_n   (rst_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .k_rise  (k_rise),
        .rd_go   (rd_go),
        .wr_go   (wr_go),
        .go_addr (go_addr),
        .err     (cmd_err)
    );

    qdrb4_burst_seq #(.AW(AW), .DELAY(WR_DLY)) u_wseq (
        .clk        (clk_beat),
        .rst_n      (rst_n),
        .start      (wr_go),
        .start_addr (go_addr),
        .beat_valid (wr_bv),
        .beat_idx   (wr_idx),
        .beat_addr  (wr_base)
    );

    qdrb4_burst_seq #(.AW(AW), .DELAY(RD_DLY)) u_rseq (
        .clk        (clk_beat),
        .rst_n      (rst_n),
        .start      (rd_go),
        .start_addr (go_addr),
        .beat_valid (rd_bv),
        .beat_idx   (rd_idx),
        .beat_addr  (rd_base)
    );

    qdrb4_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk_beat),
        .we    (wr_bv),
        .waddr ({wr_base, wr_idx}),
        .wdata (d_in),
        .raddr ({rd_base, rd_idx}),
        .rdata (rd_word)
    );

    // Output beat register: array value sampled before this edge's write lands.
    always_ff @(posedge clk_beat or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
            q_q  <= '0;
        end else begin
            oe_q <= rd_bv;
            if (rd_bv) begin
                q_q <= rd_word;
            end
        end
    end

    assign q_oe  = oe_q;
    assign q_out = oe_q ? q_q : {DW{1'bz}};

    // Every read burst keeps the bus driven for four beats.
    assert_oe_four_beats_R5: assert property (@(posedge clk_beat) disable iff (!rst_n)
        $rose(oe_q) |=> oe_q ##1 oe_q ##1 oe_q);

    // First write beat falls on a K edge.
    assert_wr_beat0_on_k_R3: assert property (@(posedge clk_beat) disable iff (!rst_n)
        (wr_bv && wr_idx == '0) |-> k_rise);

    // First read beat falls on a K edge.
    assert_rd_beat0_on_k_R4: assert property (@(posedge clk_beat) disable iff (!rst_n)
        (rd_bv && rd_idx == '0) |-> k_rise);

endmodule

// File: tb/qdrb4_sram_tb.sv
`timescale 1ns/1ps
module qdrb4_sram_tb;

    localparam int AW = 4;
    localparam int DW = 8;

    typedef struct {
        int           beat;
        logic [DW-1:0] val;
    } exp_t;

    logic          clk;
    logic          rst_n;
    logic          rd_n;
    logic          wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] d_in;
    wire  [DW-1:0] q_out;
    wire           q_oe;
    wire           cmd_err;

    qdrb4_sram #(.AW(AW), .DW(DW)) u_dut (
        .clk_beat (clk),
        .rst_n    (rst_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .d_in     (d_in),
        .q_out    (q_out),
        .q_oe     (q_oe),
        .cmd_err  (cmd_err)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int   n_chk = 0;
    int   n_fail = 0;
    int   bn = 0;
    int   last_rd = -100;
    int   last_wr = -100;
    bit   exp_err = 1'b0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    string tag = "R1";

    logic [DW-1:0] model [64];
    bit            rs_v [64];
    int            rs_a [64];
    bit            ws_v [64];
    int            ws_a [64];
    logic [DW-1:0] ws_d [64];
    exp_t          exp_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s beat %0d: actual=%0h expected=%0h", req, bn, act, exp);
        end
    endtask

    // Driver: one beat edge; scoreboard expectations are pushed before the edge.
    task automatic tick(input logic rn, input logic wn, input int a);
        int  s;
        bit  rtake;
        bit  wtake;
        if (bn % 2 == 0) begin
            rd_n = rn;
            wr_n = wn;
            addr = AW'(a);
            rtake = !rn && (bn - last_rd >= 4);
            if (!rn && !rtake) exp_err = 1'b1;
            wtake = !wn && !rtake && (bn - last_wr >= 4);
            if (!wn && !rtake && !wtake) exp_err = 1'b1;
            if (rtake) begin
                last_rd = bn;
                for (int n = 0; n < 4; n++) begin
                    s = (bn + 6 + n) % 64;
                    rs_v[s] = 1'b1;
                    rs_a[s] = a * 4 + n;
                end
            end
            if (wtake) begin
                last_wr = bn;
                for (int n = 0; n < 4; n++) begin
                    s = (bn + 2 + n) % 64;
                    ws_v[s] = 1'b1;
                    ws_a[s] = a * 4 + n;
                    ws_d[s] = DW'(bn * 13 + n * 5 + 7);
                end
            end
        end else begin
            // Odd beat edges: strobes low must be ignored (R2).
            rd_n = 1'b0;
            wr_n = 1'b0;
            addr = AW'(a + 5);
        end
        s = bn % 64;
        d_in = ws_v[s] ? ws_d[s] : DW'(bn ^ 8'h5A);
        if (rs_v[s]) begin
            exp_q.push_back('{bn, model[rs_a[s]]});
            rs_v[s] = 1'b0;
        end
        if (ws_v[s]) begin
            model[ws_a[s]] = ws_d[s];
            ws_v[s] = 1'b0;
        end
        @(posedge clk);
        bn++;
        @(negedge clk);
        #1;
    endtask

    task automatic kcyc(input logic rn, input logic wn, input int a);
        tick(rn, wn, a);
        tick(1'b1, 1'b1, 0);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) kcyc(1'b1, 1'b1, 0);
    endtask

    // Monitor: pops the scoreboard for the edge just past and compares.
    always @(negedge clk) begin
        if (mon_on && bn > 0) begin
            if (exp_q.size() > 0 && exp_q[0].beat == bn - 1) begin
                chk(q_oe === 1'b1, {"R5 ", tag}, int'(q_oe), 1);
                chk(q_out === exp_q[0].val, {"R4 R3 ", tag}, int'(q_out), int'(exp_q[0].val));
                void'(exp_q.pop_front());
            end else begin
                chk(q_oe === 1'b0, {"R5 ", tag}, int'(q_oe), 0);
            end
            chk(cmd_err === exp_err, {"R7 ", tag}, int'(cmd_err), int'(exp_err));
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            rs_v[i] = 1'b0;
            ws_v[i] = 1'b0;
        end
        rst_n = 1'b0;
        rd_n  = 1'b1;
        wr_n  = 1'b1;
        addr  = '0;
        d_in  = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(q_oe === 1'b0, "R1", int'(q_oe), 0);
        chk(cmd_err === 1'b0, "R1", int'(cmd_err), 0);
        rst_n = 1'b1;
        #1;
        mon_on = 1'b1;

        // R3: fill every burst location
        tag = "R3";
        for (int a = 0; a < 16; a++) kcyc(1'b1, 1'b0, a);
        idle(2);

        // R4: read all back, also R2 odd-edge strobes ignored throughout
        tag = "R4 R2";
        for (int a = 0; a < 16; a++) kcyc(1'b0, 1'b1, a);
        idle(2);

        // R6: write and read on consecutive K edges
        tag = "R6";
        for (int i = 0; i < 8; i++) begin
            kcyc(1'b1, 1'b0, i);
            kcyc(1'b0, 1'b1, 15 - i);
        end
        idle(3);

        // R8: write two K cycles after a read to the same words: old data
        tag = "R8";
        kcyc(1'b0, 1'b1, 2);
        kcyc(1'b1, 1'b1, 0);
        kcyc(1'b1, 1'b0, 2);
        idle(4);
        // R8: write one K cycle after a read: every word committed before read
        kcyc(1'b0, 1'b1, 4);
        kcyc(1'b1, 1'b0, 4);
        idle(4);
        // R8: read right after a write to the same address
        kcyc(1'b1, 1'b0, 6);
        kcyc(1'b0, 1'b1, 6);
        idle(4);

        // R2: both strobes low -> read only, write dropped, no error
        tag = "R2";
        kcyc(1'b0, 1'b0, 10);
        idle(2);
        kcyc(1'b0, 1'b1, 10);
        idle(4);

        // R7: early second write ignored, flag set, data unchanged
        tag = "R7";
        kcyc(1'b1, 1'b0, 7);
        kcyc(1'b1, 1'b0, 8);
        idle(2);
        kcyc(1'b0, 1'b1, 8);
        idle(2);
        // R7: blocked read does not stop a write on the same edge
        kcyc(1'b0, 1'b1, 1);
        kcyc(1'b0, 1'b0, 9);
        idle(2);
        kcyc(1'b0, 1'b1, 9);
        idle(6);

        chk(exp_q.size() == 0, "R4 drain", exp_q.size(), 0);
        mon_on = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule